// File: doc/BRIEF.md
# Video Loopback Elastic FIFO

This block moves decoded receive video words from the receiver's recovered clock domain into the transmitter's clock domain. The two clocks are unrelated. A word enters the buffer only while the receiver reports lock. The transmit side stays idle until the buffer holds at least half of its depth. From then on it delivers one word on every transmit clock. Because reading starts at the midpoint, the buffer works as a centred elastic store. It can absorb about half its depth of drift in either direction between the two clock rates.

The pointers cross between the domains as Gray code through synchronizer chains. A write attempted while the buffer is full is discarded and raises a sticky overflow flag. If the transmit side finds the buffer empty while streaming, it raises a sticky underflow flag and goes back to waiting for the half-full mark. A receiver that loses lock therefore drains the buffer, flags underflow, and restarts cleanly once lock returns.

Top module: `vid_elastic_fifo`

## Requirements
- R1: After both resets, rd_valid, rd_started, wr_overflow and rd_underflow are all 0.
- R2: A word is stored only in a write-clock cycle where wr_valid and wr_locked are both 1. With wr_locked at 0, nothing is stored and nothing later appears on rd_data.
- R3: While fewer than DEPTH/2 words are buffered, the read side stays waiting: rd_started and rd_valid remain 0.
- R4: Once DEPTH/2 words are buffered, rd_started goes to 1. After that, rd_valid is 1 on every read-clock cycle until the buffer runs empty, with no gaps.
- R5: Words leave on rd_data in the order they were stored, with their bit values unchanged.
- R6: A write attempted while the buffer holds DEPTH words is discarded and sets wr_overflow. The flag stays set until the write-side reset. The discarded word never appears on rd_data.
- R7: When the buffer is empty while streaming, rd_underflow is set and stays set until the read-side reset. In the same cycle rd_started returns to 0. Streaming resumes only after DEPTH/2 words are buffered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Receive recovered clock |
| wr_rst_n | input | 1 | Active-low reset, write domain |
| wr_locked | input | 1 | Receiver lock indication; gates writes |
| wr_valid | input | 1 | Decoded word present on wr_data |
| wr_data | input | DATA_W | Decoded receive word |
| wr_overflow | output | 1 | Sticky: a write was dropped because the buffer was full |
| rd_clk | input | 1 | Transmit clock |
| rd_rst_n | input | 1 | Active-low reset, read domain |
| rd_data | output | DATA_W | Word for the transmit encoder |
| rd_valid | output | 1 | rd_data holds a buffered word this cycle |
| rd_started | output | 1 | Read side is streaming (past the half-full start) |
| rd_underflow | output | 1 | Sticky: the buffer ran empty while streaming |

## Verification
Bursts of every length from one word up to the full depth are written, each after a fresh reset. This shows exactly where the half-full start threshold lies. It also shows that every started burst drains gaplessly and in order before underflow is reported. A second burst after an underflow, with no reset in between, shows that the buffer waits for the midpoint again. Words offered without lock, including a lock drop inside a burst, must never surface at the read port. An overfill with the read side held in reset separates the words that were kept from the words that were dropped, and checks that the overflow flag is sticky.

// File: rtl/vef_pkg.sv
package vef_pkg;

    typedef enum logic {
        RD_WAIT   = 1'b0,
        RD_STREAM = 1'b1
    } rd_mode_e;

endpackage

// File: rtl/vef_ram.sv
module vef_ram #(
    parameter  int DATA_W = 20,
    parameter  int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    // read is combinational; the read controller registers the word
    assign rdata = store_q[raddr];

endmodule

// File: rtl/vef_gray_sync.sv
module vef_gray_sync #(
    parameter int PTR_W  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] gray_in,
    output logic [PTR_W-1:0] bin_out
);

    logic [PTR_W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= gray_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    // Gray to binary conversion of the settled value
    always_comb begin
        bin_out[PTR_W-1] = stage_q[STAGES-1][PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ stage_q[STAGES-1][i];
        end
    end

endmodule

// File: rtl/vef_wr_ctrl.sv
module vef_wr_ctrl #(
    parameter  int DATA_W = 20,
    parameter  int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              locked,
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    input  logic [PTR_W-1:0]  rd_bin_s,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [PTR_W-1:0]  wr_gray,
    output logic              overflow
);

    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
        logic             ovf;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic      accept;
    logic      full;

    always_comb begin
        st_d   = st_q;
        accept = locked && valid;
        full   = (st_q.bin - rd_bin_s) == PTR_W'(DEPTH);
        mem_we = accept && !full;
        if (mem_we) begin
            st_d.bin = st_q.bin + 1'b1;
        end
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
        if (accept && full) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_waddr = st_q.bin[ADDR_W-1:0];
    assign mem_wdata = data;
    assign wr_gray   = st_q.gray;
    assign overflow  = st_q.ovf;

endmodule

// File: rtl/vef_rd_ctrl.sv
module vef_rd_ctrl
    import vef_pkg::*;
#(
    parameter  int DATA_W = 20,
    parameter  int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1,
    localparam int HALF   = DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  wr_bin_s,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [PTR_W-1:0]  rd_gray,
    output logic [DATA_W-1:0] data,
    output logic              valid,
    output logic              started,
    output logic              underflow
);

    typedef struct packed {
        rd_mode_e          mode;
        logic [PTR_W-1:0]  bin;
        logic [PTR_W-1:0]  gray;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              unf;
    } rd_state_t;

    rd_state_t        st_d, st_q;
    logic [PTR_W-1:0] fill;

    always_comb begin
        st_d       = st_q;
        fill       = wr_bin_s - st_q.bin;
        st_d.valid = 1'b0;
        case (st_q.mode)
            RD_WAIT: begin
                if (fill >= PTR_W'(HALF)) begin
                    st_d.mode = RD_STREAM;
                end
            end
            RD_STREAM: begin
                if (fill != '0) begin
                    st_d.data  = mem_rdata;
                    st_d.valid = 1'b1;
                    st_d.bin   = st_q.bin + 1'b1;
                end else begin
                    st_d.unf  = 1'b1;
                    st_d.mode = RD_WAIT;
                end
            end
            default: st_d.mode = RD_WAIT;
        endcase
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= RD_WAIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_raddr = st_q.bin[ADDR_W-1:0];
    assign rd_gray   = st_q.gray;
    assign data      = st_q.data;
    assign valid     = st_q.valid;
    assign started   = (st_q.mode == RD_STREAM);
    assign underflow = st_q.unf;

endmodule

// File: rtl/vid_elastic_fifo.sv
module vid_elastic_fifo #(
    parameter  int DATA_W      = 20,
    parameter  int DEPTH       = 64,
    parameter  int SYNC_STAGES = 2,
    localparam int ADDR_W      = $clog2(DEPTH),
    localparam int PTR_W       = ADDR_W + 1
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_locked,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_overflow,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_started,
    output logic              rd_underflow
);

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic [PTR_W-1:0]  wr_gray;
    logic [PTR_W-1:0]  rd_gray;
    logic [PTR_W-1:0]  wr_bin_in_rd;
    logic [PTR_W-1:0]  rd_bin_in_wr;

    vef_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .wclk  (wr_clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    vef_wr_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_wr (
        .clk       (wr_clk),
        .rst_n     (wr_rst_n),
        .locked    (wr_locked),
        .valid     (wr_valid),
        .data      (wr_data),
        .rd_bin_s  (rd_bin_in_wr),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .wr_gray   (wr_gray),
        .overflow  (wr_overflow)
    );

    vef_gray_sync #(.PTR_W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_w2r (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .gray_in (wr_gray),
        .bin_out (wr_bin_in_rd)
    );

    vef_gray_sync #(.PTR_W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_r2w (
        .clk     (wr_clk),
        .rst_n   (wr_rst_n),
        .gray_in (rd_gray),
        .bin_out (rd_bin_in_wr)
    );

    vef_rd_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .wr_bin_s  (wr_bin_in_rd),
        .mem_rdata (mem_rdata),
        .mem_raddr (mem_raddr),
        .rd_gray   (rd_gray),
        .data      (rd_data),
        .valid     (rd_valid),
        .started   (rd_started),
        .underflow (rd_underflow)
    );

endmodule

// File: rtl/vef_checker.sv
module vef_checker #(
    parameter int PTR_W = 7
) (
    input logic             wr_clk,
    input logic             wr_rst_n,
    input logic             wr_locked,
    input logic             wr_overflow,
    input logic [PTR_W-1:0] wr_gray,
    input logic             rd_clk,
    input logic             rd_rst_n,
    input logic             rd_valid,
    input logic             rd_started,
    input logic             rd_underflow
);

    // R2: without lock the write pointer must not move
    assert_no_write_unlocked_R2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !wr_locked |=> $stable(wr_gray));

    // R3: no word is presented outside the streaming phase
    assert_valid_only_streaming_R3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_valid |-> rd_started);

    // R5: the pointer that crosses domains changes at most one bit per cycle
    assert_wr_gray_step_R5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    // R6: overflow flag is sticky
    assert_overflow_sticky_R6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_overflow |=> wr_overflow);

    // R7: underflow flag is sticky
    assert_underflow_sticky_R7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_underflow |=> rd_underflow);

    // R7: underflow coincides with a return to waiting
    assert_underflow_stops_R7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $rose(rd_underflow) |-> !rd_started);

endmodule

bind vid_elastic_fifo vef_checker #(.PTR_W(PTR_W)) u_chk (
    .wr_clk       (wr_clk),
    .wr_rst_n     (wr_rst_n),
    .wr_locked    (wr_locked),
    .wr_overflow  (wr_overflow),
    .wr_gray      (wr_gray),
    .rd_clk       (rd_clk),
    .rd_rst_n     (rd_rst_n),
    .rd_valid     (rd_valid),
    .rd_started   (rd_started),
    .rd_underflow (rd_underflow)
);

// File: tb/vid_elastic_fifo_tb.sv
module vid_elastic_fifo_tb;

    localparam int W     = 8;
    localparam int DEPTH = 8;
    localparam int HALF  = DEPTH / 2;

    logic         clk = 1'b0;
    logic         wr_rst_n = 1'b0;
    logic         rd_rst_n = 1'b0;
    logic         wr_locked = 1'b0;
    logic         wr_valid = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         wr_overflow;
    logic [W-1:0] rd_data;
    logic         rd_valid;
    logic         rd_started;
    logic         rd_underflow;

    always #5 clk = ~clk;

    vid_elastic_fifo #(.DATA_W(W), .DEPTH(DEPTH)) u_dut (
        .wr_clk       (clk),
        .wr_rst_n     (wr_rst_n),
        .wr_locked    (wr_locked),
        .wr_valid     (wr_valid),
        .wr_data      (wr_data),
        .wr_overflow  (wr_overflow),
        .rd_clk       (clk),
        .rd_rst_n     (rd_rst_n),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .rd_started   (rd_started),
        .rd_underflow (rd_underflow)
    );

    int           vectors = 0;
    int           errors  = 0;
    int           cyc     = 0;
    int           widx    = 0;
    int           seq     = 0;
    int           ridx    = 0;
    int           first_t = 0;
    int           last_t  = 0;
    bit           saw_started = 1'b0;
    logic [W-1:0] exp_mem [64];

    always @(posedge clk) cyc <= cyc + 1;

    // Read-side monitor: every delivered word is compared in order (R5)
    always @(negedge clk) begin
        if (!rd_rst_n) begin
            ridx        = 0;
            saw_started = 1'b0;
        end else begin
            if (rd_started) saw_started = 1'b1;
            if (rd_valid) begin
                vectors++;
                if (rd_data !== exp_mem[ridx]) begin
                    errors++;
                    $display("FAIL R5 word %0d: actual %0h expected %0h", ridx, rd_data, exp_mem[ridx]);
                end
                if (ridx == 0) first_t = cyc;
                last_t = cyc;
                ridx++;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        wr_rst_n  = 1'b0;
        rd_rst_n  = 1'b0;
        wr_valid  = 1'b0;
        wr_locked = 1'b0;
        repeat (3) @(negedge clk);
        widx     = 0;
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        #2;
    endtask

    // one write-clock cycle of offered data; keep marks words expected to be stored
    task automatic wr_word(input bit lk, input bit keep);
        @(negedge clk);
        wr_valid  = 1'b1;
        wr_locked = lk;
        wr_data   = W'(seq * 37 + 5);
        seq++;
        if (keep) begin
            exp_mem[widx] = wr_data;
            widx++;
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        wr_valid = 1'b0;
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 rd_started", int'(rd_started), 0);
        chk("R1 wr_overflow", int'(wr_overflow), 0);
        chk("R1 rd_underflow", int'(rd_underflow), 0);

        // Burst-length sweep: threshold (R3/R4), order (R5), drain and underflow (R7)
        for (int n = 1; n <= DEPTH; n++) begin
            do_reset();
            for (int k = 0; k < n; k++) wr_word(1'b1, 1'b1);
            idle(30);
            chk("R7 started low after burst", int'(rd_started), 0);
            if (n < HALF) begin
                chk("R3 no words below half", ridx, 0);
                chk("R3 never started", int'(saw_started), 0);
                chk("R3 no underflow", int'(rd_underflow), 0);
            end else begin
                chk("R4 started seen", int'(saw_started), 1);
                chk("R5 word count", ridx, n);
                chk("R4 gapless span", last_t - first_t, n - 1);
                chk("R7 underflow set", int'(rd_underflow), 1);
            end
        end

        // R7: restart after underflow without reset (continues from DEPTH words)
        for (int k = 0; k < HALF - 1; k++) wr_word(1'b1, 1'b1);
        idle(30);
        chk("R7 waits again below half", ridx, DEPTH);
        wr_word(1'b1, 1'b1);
        idle(30);
        chk("R7 restart count", ridx, DEPTH + HALF);
        chk("R7 underflow still set", int'(rd_underflow), 1);
        chk("R7 started low", int'(rd_started), 0);

        // R2: lock gating, including a lock drop inside a burst
        do_reset();
        for (int k = 0; k < 6; k++) wr_word(1'b0, 1'b0);
        idle(30);
        chk("R2 unlocked words absent", ridx, 0);
        chk("R2 unlocked no start", int'(saw_started), 0);
        for (int k = 0; k < 5; k++) wr_word(1'b1, 1'b1);
        for (int k = 0; k < 4; k++) wr_word(1'b0, 1'b0);
        idle(30);
        chk("R2 only locked words out", ridx, 5);

        // R6: overfill with the read side held in reset
        @(negedge clk);
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        wr_valid = 1'b0;
        repeat (3) @(negedge clk);
        widx     = 0;
        wr_rst_n = 1'b1;
        for (int k = 0; k < DEPTH; k++) wr_word(1'b1, 1'b1);
        idle(2);
        chk("R6 no overflow at full", int'(wr_overflow), 0);
        wr_word(1'b1, 1'b0);
        wr_word(1'b1, 1'b0);
        idle(2);
        chk("R6 overflow set", int'(wr_overflow), 1);
        @(negedge clk);
        rd_rst_n = 1'b1;
        idle(30);
        chk("R6 dropped words absent", ridx, DEPTH);
        chk("R4 full drain gapless", last_t - first_t, DEPTH - 1);
        chk("R7 underflow after drain", int'(rd_underflow), 1);
        chk("R6 overflow sticky", int'(wr_overflow), 1);
        do_reset();
        chk("R6 overflow cleared by reset", int'(wr_overflow), 0);
        chk("R1 underflow cleared by reset", int'(rd_underflow), 0);

        summary();
        $finish;
    end

endmodule